// File: doc/BRIEF.md
# Memory-to-Memory Byte Copy Engine

This block copies a run of bytes from one region of memory to another without processor help. Software sets up a small bank of 8-bit registers: a 16-bit source address, a 16-bit destination address, a byte count, and a step direction for each address. It then starts the copy by writing a control byte that has both the enable bit and the start bit set. For each byte the engine issues a read on its memory port, waits for the grant, and then issues a write of that byte to the destination, also waiting for the grant. After each access it moves the address it used up or down by one.

When the last byte has been written, the engine sets a completion flag that stays set until software clears it. The interrupt line is high while that flag and the interrupt enable are both set. Two 2-bit priority fields are only stored and driven out: one goes to the interrupt controller and one to the memory arbiter, and the copy itself does not use them. Clearing the enable bit during a copy stops it cleanly at the next byte boundary.

Top module: `m2m_copy_engine`

## Requirements
- R1: After reset every register reads 0x00, `mem_req` is low and `irq` is low.
- R2: Register offsets are fixed as follows.
  - 0x00 is the setup register: bit 7 interrupt enable, bit 5 source step, bit 4 destination step, bits 3:2 interrupt level, bits 1:0 bus level. Bit 6 always reads 0.
  - 0x01 is the control register: bit 7 enable, bit 6 start. The start bit always reads 0.
  - 0x02 is the status register.
  - 0x03 is the count register.
  - 0x04 and 0x05 are the source address, high byte then low byte.
  - 0x06 and 0x07 are the destination address, high byte then low byte.
  - Every written field reads back.
- R3: Each copy moves count+1 bytes. Each byte is one read request followed by one write request. Each request stays asserted, with a stable address, until `mem_gnt` is high at a clock edge.
- R4: When source step bit 5 is 0, the read address rises by one after each byte. When it is 1, the read address falls by one.
- R5: When destination step bit 4 is 0, the write address rises by one after each byte. When it is 1, it falls by one. This does not depend on the source step.
- R6: Both working addresses wrap modulo 65536: 0xFFFF+1 gives 0x0000, and 0x0000-1 gives 0xFFFF.
- R7: A control write with bit 7 and bit 6 both set starts a copy only while the engine is idle. A start while a copy is running is ignored. A start with bit 7 clear is ignored. A write with bit 6 clear starts nothing.
- R8: Status bit 0 is set when a copy finishes and stays set until software writes the status register with bit 0 equal to 0. Writing it with bit 0 equal to 1 has no effect. Status bit 7 reads 1 while a copy is running.
- R9: `irq` equals status bit 0 AND setup bit 7.
- R10: `irq_prio` shows setup bits 3:2, and `bus_prio` shows setup bits 1:0.
- R11: Writing enable=0 during a copy stops the engine after the byte in flight completes. No read is left without its write, and status bit 0 is not set.
- R12: A copy does not change the programmed address and count registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write access, 0 = read access |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid with grant on a read |
| mem_gnt | input | 1 | Access completes at this clock edge |
| irq | output | 1 | Completion interrupt |
| irq_prio | output | 2 | Interrupt level for the interrupt controller |
| bus_prio | output | 2 | Bus access level for the arbiter |

## Verification
The assertions check the memory-port handshake on every cycle:
- A pending write keeps its address and data until it is granted.
- Every granted read is followed straight away by a write request.
- No request appears while the engine is idle.
- The completion flag is set after each finish and only a clearing write can drop it.

The things that depend on a whole copy can only be shown by the bench's scenarios:
- the right bytes land at the right addresses for each direction pair and across the wraps;
- the byte count is exact;
- a start during a copy is ignored;
- a stop request leaves no read without its write and does not set the flag.

// File: rtl/m2m_pkg.sv
package m2m_pkg;

    localparam logic [2:0] OFF_SETUP = 3'd0;
    localparam logic [2:0] OFF_CTRL  = 3'd1;
    localparam logic [2:0] OFF_STAT  = 3'd2;
    localparam logic [2:0] OFF_COUNT = 3'd3;
    localparam logic [2:0] OFF_SRC_H = 3'd4;
    localparam logic [2:0] OFF_SRC_L = 3'd5;
    localparam logic [2:0] OFF_DST_H = 3'd6;
    localparam logic [2:0] OFF_DST_L = 3'd7;

    typedef struct packed {
        logic       irq_en;
        logic       src_down;
        logic       dst_down;
        logic [1:0] irq_lvl;
        logic [1:0] bus_lvl;
    } setup_t;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_READ = 2'd1,
        SQ_WRITE = 2'd2
    } seq_state_e;

endpackage

// File: rtl/m2m_addr_step.sv
module m2m_addr_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] cur,
    input  logic         down,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        if (down) nxt = cur - ONE;
        else      nxt = cur + ONE;
    end
endmodule

// File: rtl/m2m_regs.sv
module m2m_regs
    import m2m_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              busy,
    input  logic              done,
    output setup_t            setup,
    output logic              enable,
    output logic              start,
    output logic              flag,
    output logic [CNT_W-1:0]  count,
    output logic [ADDR_W-1:0] src_base,
    output logic [ADDR_W-1:0] dst_base,
    output logic              irq
);
    localparam int HI_W = ADDR_W - 8;

    typedef struct packed {
        setup_t              setup;
        logic                enable;
        logic                flag;
        logic [CNT_W-1:0]    count;
        logic [ADDR_W-1:0]   src;
        logic [ADDR_W-1:0]   dst;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d   = r_q;
        start = 1'b0;
        if (reg_we) begin
            unique case (reg_addr)
                OFF_SETUP: r_d.setup = setup_t'({reg_wdata[7], reg_wdata[5:0]});
                OFF_CTRL: begin
                    r_d.enable = reg_wdata[7];
                    start      = reg_wdata[7] & reg_wdata[6] & ~busy;
                end
                OFF_STAT:  if (!reg_wdata[0]) r_d.flag = 1'b0;
                OFF_COUNT: r_d.count = reg_wdata[CNT_W-1:0];
                OFF_SRC_H: r_d.src[ADDR_W-1:8] = reg_wdata[HI_W-1:0];
                OFF_SRC_L: r_d.src[7:0] = reg_wdata;
                OFF_DST_H: r_d.dst[ADDR_W-1:8] = reg_wdata[HI_W-1:0];
                OFF_DST_L: r_d.dst[7:0] = reg_wdata;
                default: ;
            endcase
        end
        if (done) r_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFF_SETUP: reg_rdata = {r_q.setup.irq_en, 1'b0, r_q.setup.src_down,
                                    r_q.setup.dst_down, r_q.setup.irq_lvl, r_q.setup.bus_lvl};
            OFF_CTRL:  reg_rdata = {r_q.enable, 7'd0};
            OFF_STAT:  reg_rdata = {busy, 6'd0, r_q.flag};
            OFF_COUNT: reg_rdata[CNT_W-1:0] = r_q.count;
            OFF_SRC_H: reg_rdata[HI_W-1:0] = r_q.src[ADDR_W-1:8];
            OFF_SRC_L: reg_rdata = r_q.src[7:0];
            OFF_DST_H: reg_rdata[HI_W-1:0] = r_q.dst[ADDR_W-1:8];
            OFF_DST_L: reg_rdata = r_q.dst[7:0];
            default:   reg_rdata = '0;
        endcase
    end

    assign setup    = r_q.setup;
    assign enable   = r_q.enable;
    assign flag     = r_q.flag;
    assign count    = r_q.count;
    assign src_base = r_q.src;
    assign dst_base = r_q.dst;
    assign irq      = r_q.flag & r_q.setup.irq_en;
endmodule

// File: rtl/m2m_seq.sv
module m2m_seq
    import m2m_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              enable,
    input  logic              src_down,
    input  logic              dst_down,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic [CNT_W-1:0]  count,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_gnt,
    output logic              busy,
    output logic              done
);
    localparam logic [CNT_W-1:0] ONE_LEFT = CNT_W'(1);

    typedef struct packed {
        seq_state_e          state;
        logic [ADDR_W-1:0]   src;
        logic [ADDR_W-1:0]   dst;
        logic [CNT_W-1:0]    left;
        logic [7:0]          data;
    } seq_t;

    seq_t s_d, s_q;
    logic [ADDR_W-1:0] src_nxt, dst_nxt;

    m2m_addr_step #(.W(ADDR_W)) u_src_step (.cur(s_q.src), .down(src_down), .nxt(src_nxt));
    m2m_addr_step #(.W(ADDR_W)) u_dst_step (.cur(s_q.dst), .down(dst_down), .nxt(dst_nxt));

    always_comb begin
        s_d       = s_q;
        done      = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = s_q.src;
        mem_wdata = s_q.data;
        unique case (s_q.state)
            SQ_IDLE: begin
                if (start) begin
                    s_d.state = SQ_READ;
                    s_d.src   = src_base;
                    s_d.dst   = dst_base;
                    s_d.left  = count;
                end
            end
            SQ_READ: begin
                if (!enable) begin
                    s_d.state = SQ_IDLE;
                end else begin
                    mem_req = 1'b1;
                    if (mem_gnt) begin
                        s_d.data  = mem_rdata;
                        s_d.src   = src_nxt;
                        s_d.state = SQ_WRITE;
                    end
                end
            end
            SQ_WRITE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = s_q.dst;
                if (mem_gnt) begin
                    s_d.dst = dst_nxt;
                    if (s_q.left == '0) begin
                        done      = 1'b1;
                        s_d.state = SQ_IDLE;
                    end else begin
                        s_d.left  = s_q.left - ONE_LEFT;
                        s_d.state = SQ_READ;
                    end
                end
            end
            default: s_d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{state: SQ_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign busy = (s_q.state != SQ_IDLE);
endmodule

// File: rtl/m2m_copy_engine.sv
module m2m_copy_engine
    import m2m_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_gnt,
    output logic              irq,
    output logic [1:0]        irq_prio,
    output logic [1:0]        bus_prio
);
    setup_t            setup_w;
    logic              enable_w, start_w, flag_w, busy_w, done_w;
    logic [CNT_W-1:0]  count_w;
    logic [ADDR_W-1:0] src_base_w, dst_base_w;

    m2m_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy_w), .done(done_w),
        .setup(setup_w), .enable(enable_w), .start(start_w), .flag(flag_w),
        .count(count_w), .src_base(src_base_w), .dst_base(dst_base_w), .irq(irq)
    );

    m2m_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start(start_w), .enable(enable_w),
        .src_down(setup_w.src_down), .dst_down(setup_w.dst_down),
        .src_base(src_base_w), .dst_base(dst_base_w), .count(count_w),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_gnt(mem_gnt),
        .busy(busy_w), .done(done_w)
    );

    assign irq_prio = setup_w.irq_lvl;
    assign bus_prio = setup_w.bus_lvl;
endmodule

// File: rtl/m2m_checker.sv
module m2m_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [2:0]        reg_addr,
    input logic [7:0]        reg_wdata,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_gnt,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_wdata,
    input logic              busy,
    input logic              done,
    input logic              flag
);
    logic clear_wr;
    assign clear_wr = reg_we && (reg_addr == 3'd2) && !reg_wdata[0];

    // R3: a pending write holds its address and data until granted
    p_wr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && !mem_gnt |=> mem_req && mem_we && $stable(mem_addr) && $stable(mem_wdata));

    // R3: a granted read is followed at once by the write of that byte
    p_rd_then_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && mem_gnt |=> mem_req && mem_we);

    // R7: an idle engine makes no memory request
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R8: finishing a copy sets the flag
    p_done_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> flag);

    // R8: only a clearing status write drops the flag
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !clear_wr |=> flag);
endmodule

bind m2m_copy_engine m2m_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_gnt(mem_gnt),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .busy(busy_w), .done(done_w), .flag(flag_w)
);

// File: tb/tb_m2m_copy_engine.sv
`timescale 1ns/1ps
module tb_m2m_copy_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        mem_gnt = 1'b0;
    logic        irq;
    logic [1:0]  irq_prio, bus_prio;

    m2m_copy_engine dut (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_gnt(mem_gnt),
        .irq(irq), .irq_prio(irq_prio), .bus_prio(bus_prio)
    );

    always #4 clk = ~clk;

    int n_chk = 0, n_bad = 0, cyc = 0;
    int stall_cfg = 0, wait_cnt = 0;
    int rd_cnt = 0, wr_cnt = 0;
    logic [7:0] wmem [int];

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL R3 watchdog expired actual=%0d expected=%0d", cyc, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
        if (mem_req && mem_gnt) begin
            if (mem_we) begin
                wmem[int'(mem_addr)] = mem_wdata;
                wr_cnt++;
            end else begin
                rd_cnt++;
            end
        end
    end

    // memory model: grant after stall_cfg waiting cycles
    always @(negedge clk) begin
        if (!mem_req) begin
            mem_gnt  = 1'b0;
            wait_cnt = 0;
        end else if (wait_cnt >= stall_cfg) begin
            mem_gnt   = 1'b1;
            mem_rdata = pat(mem_addr);
            wait_cnt  = 0;
        end else begin
            mem_gnt = 1'b0;
            wait_cnt++;
        end
    end

    task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        int t = 0;
        do begin
            reg_rd(3'd2, s);
            t++;
        end while (s[7] && t < 20000);
    endtask

    task automatic prog(input logic [15:0] s, input logic [15:0] d, input logic [7:0] n);
        reg_wr(3'd3, n);
        reg_wr(3'd4, s[15:8]); reg_wr(3'd5, s[7:0]);
        reg_wr(3'd6, d[15:8]); reg_wr(3'd7, d[7:0]);
        rd_cnt = 0; wr_cnt = 0;
        wmem.delete();
    endtask

    typedef struct packed {
        logic [15:0] src;
        logic [15:0] dst;
        logic [7:0]  n;
        logic        sdown;
        logic        ddown;
        logic        ie;
        logic [1:0]  stall;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{16'h1000, 16'h2000, 8'd3, 1'b0, 1'b0, 1'b1, 2'd0},
        '{16'h3010, 16'h4000, 8'd4, 1'b1, 1'b0, 1'b1, 2'd1},
        '{16'h5000, 16'h6010, 8'd5, 1'b0, 1'b1, 1'b0, 2'd2},
        '{16'h0002, 16'h8000, 8'd4, 1'b1, 1'b0, 1'b1, 2'd0},
        '{16'h9000, 16'h0001, 8'd3, 1'b0, 1'b1, 1'b1, 2'd3},
        '{16'hA0FF, 16'hB100, 8'd0, 1'b0, 1'b0, 1'b1, 2'd3},
        '{16'hFFFE, 16'hC000, 8'd3, 1'b0, 1'b0, 1'b1, 2'd1}
    };

    initial begin
        logic [7:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            reg_rd(3'(a), rv);
            chk(rv == 8'h00, "R1 register reset value", rv, 0);
        end
        chk(mem_req == 1'b0, "R1 mem_req after reset", mem_req, 0);
        chk(irq == 1'b0, "R1 irq after reset", irq, 0);

        // R2: readback, bit 6 of setup reads 0
        reg_wr(3'd0, 8'hFF);
        reg_rd(3'd0, rv);
        chk(rv == 8'hBF, "R2 setup readback", rv, 8'hBF);
        // R10: levels driven out
        reg_wr(3'd0, 8'h09);
        chk(irq_prio == 2'd2 && bus_prio == 2'd1, "R10 levels 09", {irq_prio, bus_prio}, 4'b1001);
        reg_wr(3'd0, 8'h06);
        chk(irq_prio == 2'd1 && bus_prio == 2'd2, "R10 levels 06", {irq_prio, bus_prio}, 4'b0110);
        prog(16'h1234, 16'hABCD, 8'h5A);
        reg_rd(3'd3, rv); chk(rv == 8'h5A, "R2 count readback", rv, 8'h5A);
        reg_rd(3'd4, rv); chk(rv == 8'h12, "R2 source high readback", rv, 8'h12);
        reg_rd(3'd7, rv); chk(rv == 8'hCD, "R2 destination low readback", rv, 8'hCD);

        // R7: start bit without enable, and enable without start bit
        reg_wr(3'd1, 8'h40);
        reg_rd(3'd2, rv);
        chk(rv == 8'h00, "R7 start with enable clear ignored", rv, 0);
        reg_wr(3'd1, 8'h80);
        repeat (3) @(negedge clk);
        reg_rd(3'd2, rv);
        chk(rv == 8'h00 && rd_cnt == 0, "R7 enable alone starts nothing", rv, 0);
        reg_rd(3'd1, rv);
        chk(rv == 8'h80, "R2 control reads enable, start reads 0", rv, 8'h80);

        // table walk: R3 R4 R5 R6 R8 R9 R12
        for (int v = 0; v < NV; v++) begin
            vec_t t;
            int bad;
            t = VECS[v];
            reg_wr(3'd0, {t.ie, 1'b0, t.sdown, t.ddown, 4'b0110});
            prog(t.src, t.dst, t.n);
            stall_cfg = int'(t.stall);
            reg_wr(3'd1, 8'hC0);
            wait_idle();
            chk(rd_cnt == int'(t.n) + 1, "R3 read count", rd_cnt, int'(t.n) + 1);
            chk(wr_cnt == int'(t.n) + 1, "R3 write count", wr_cnt, int'(t.n) + 1);
            bad = 0;
            for (int i = 0; i <= int'(t.n); i++) begin
                logic [15:0] sa, da;
                sa = t.sdown ? t.src - 16'(i) : t.src + 16'(i);
                da = t.ddown ? t.dst - 16'(i) : t.dst + 16'(i);
                if (!wmem.exists(int'(da))) bad++;
                else if (wmem[int'(da)] != pat(sa)) bad++;
            end
            chk(bad == 0, "R4 R5 R6 byte placement", bad, 0);
            reg_rd(3'd2, rv);
            chk(rv == 8'h01, "R8 flag set on completion", rv, 1);
            chk(irq == t.ie, "R9 irq follows flag and enable", irq, t.ie);
            reg_rd(3'd5, rv);
            chk(rv == t.src[7:0], "R12 source register unchanged", rv, t.src[7:0]);
            reg_rd(3'd6, rv);
            chk(rv == t.dst[15:8], "R12 destination register unchanged", rv, t.dst[15:8]);
            reg_rd(3'd3, rv);
            chk(rv == t.n, "R12 count register unchanged", rv, t.n);
            reg_wr(3'd2, 8'h01);
            reg_rd(3'd2, rv);
            chk(rv == 8'h01, "R8 writing bit0=1 keeps flag", rv, 1);
            reg_wr(3'd2, 8'h00);
            reg_rd(3'd2, rv);
            chk(rv == 8'h00 && irq == 1'b0, "R8 R9 flag cleared by software", rv, 0);
        end

        // R7: start while busy is ignored
        reg_wr(3'd0, 8'h80);
        prog(16'h1100, 16'h2200, 8'd20);
        stall_cfg = 2;
        reg_wr(3'd1, 8'hC0);
        reg_rd(3'd2, rv);
        chk(rv[7] == 1'b1, "R8 busy bit during copy", rv[7], 1);
        repeat (10) @(negedge clk);
        reg_wr(3'd1, 8'hC0);
        wait_idle();
        chk(wr_cnt == 21, "R7 restart while busy ignored", wr_cnt, 21);
        chk(wmem.exists(int'(16'h2214)) && !wmem.exists(int'(16'h2215)),
            "R7 copy not restarted", wr_cnt, 21);
        reg_wr(3'd2, 8'h00);

        // R11: stop request mid-copy
        prog(16'h1300, 16'h2400, 8'd30);
        stall_cfg = 1;
        reg_wr(3'd1, 8'hC0);
        repeat (12) @(negedge clk);
        reg_wr(3'd1, 8'h00);
        wait_idle();
        reg_rd(3'd2, rv);
        chk(rv == 8'h00, "R11 stop leaves flag clear", rv, 0);
        chk(wr_cnt == rd_cnt, "R11 no read left without its write", wr_cnt, rd_cnt);
        chk(wr_cnt > 0 && wr_cnt < 31, "R11 copy cut short", wr_cnt, 15);
        chk(irq == 1'b0, "R11 no interrupt after stop", irq, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule